// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block receives write transfers on a two-wire serial bus (I2C) and keeps the control settings of a TV audio processor in a small, sparse set of subaddressed registers. A host sends a START, the 7-bit device address with the write bit, a subaddress byte and then any number of data bytes, and closes with a STOP. The block acknowledges each accepted byte by pulling the data line low during the ninth clock. After every data byte it steps the subaddress, so one burst can fill several registers in a row.

The register fields come out in parallel: common volume, left and right volume, bass, treble, the SCART-path switching byte and the loudspeaker-path switching byte. Two general-purpose port pins follow two bits of the SCART switching byte. Both bus lines are oversampled by the system clock, so the bus may run at any rate well below it. After power-on both channel mute bits are set, so the audio paths start silent until the host clears them.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: The block answers the 7-bit address 1000000 when `addr_sel` is 0 and 1000001 when `addr_sel` is 1, with the R/W bit (bit 0 of the first byte) equal to 0; it acknowledges by asserting `sda_drive_low` during the ninth clock of that byte.
- R2: On an address mismatch, or when the R/W bit is 1, `sda_drive_low` stays 0 for that byte and all bytes up to the next START, and no register changes.
- R3: The byte after the address is the subaddress; each following data byte is written to the current subaddress, and the subaddress then steps by one.
- R4: Subaddress 00h holds common volume in data bits 5:0, 01h left volume in bits 4:0, 02h right volume in bits 4:0, 03h bass in bits 4:0 and 04h treble in bits 3:0; the upper bits of each data byte are dropped.
- R5: Subaddress 08h stores data bits 6:0 into `scart_ctrl` (bit 6 mute, bit 5 port 1, bit 4 port 2, bits 3:0 source select); subaddress 09h stores all 8 bits into `spkr_ctrl` (bit 7 and bit 5 effect controls, bit 6 mute, bit 4 stereo/mono effect, bits 3:0 source select).
- R6: Data bytes at subaddresses 05h to 07h and at 0Ah and above are acknowledged and discarded, and the subaddress still steps past them, so a burst from 04h reaches 08h after three filler bytes.
- R7: After reset `scart_ctrl` is 40h, `spkr_ctrl` is 40h (both mutes set), and every other register field and both ports are 0.
- R8: `port1` equals `scart_ctrl` bit 5 and `port2` equals `scart_ctrl` bit 4.
- R9: A repeated START restarts address reception, and after a STOP clock pulses without a new START are ignored (no acknowledge, no write).
- R10: `sda_drive_low` changes only while SCL is low, is asserted for the ninth clock of every accepted data byte, and is released after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| addr_sel | input | 1 | Selects the low address bit |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_drive_low | output | 1 | 1 pulls the data line low (acknowledge) |
| vol_common | output | 6 | Common volume code |
| vol_left | output | 5 | Left volume code |
| vol_right | output | 5 | Right volume code |
| bass | output | 5 | Bass code |
| treble | output | 4 | Treble code |
| scart_ctrl | output | 7 | SCART-path switching byte, bits 6:0 |
| spkr_ctrl | output | 8 | Loudspeaker-path switching byte |
| port1 | output | 1 | General-purpose port 1 level |
| port2 | output | 1 | General-purpose port 2 level |

## Verification
The bench drives bursts that run through the empty slots between treble and the switching bytes; a design that skipped the step on discarded bytes would land the switching data in the wrong register. It sends the wrong address, the read bit and clock pulses after a STOP, where a slave that kept listening would acknowledge and overwrite settings. A repeated START in mid-transfer checks that the second address byte is not taken as data, and writes with all upper bits set catch fields that were stored too wide. The reset check catches mutes that come up clear, which would let audio through before the host configures the part.

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_BASE   = 6'b100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  output logic [5:0] vol_common,
  output logic [4:0] vol_left,
  output logic [4:0] vol_right,
  output logic [4:0] bass,
  output logic [3:0] treble,
  output logic [6:0] scart_ctrl,
  output logic [7:0] spkr_ctrl,
  output logic       port1,
  output logic       port2
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_SUB, S_DATA} rx_state_t;

  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic addr_hit, idle_w;

  rx_state_t  state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] subaddr;
  logic       in_ack;
  logic       sda_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign scl_d = scl_pipe[SYNC_STAGES];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign sda_d = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign addr_hit  = (shreg[7:1] == {ADDR_BASE, addr_sel}) && !shreg[0];
  assign idle_w    = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      subaddr    <= '0;
      in_ack     <= 1'b0;
      sda_lo     <= 1'b0;
      vol_common <= '0;
      vol_left   <= '0;
      vol_right  <= '0;
      bass       <= '0;
      treble     <= '0;
      scart_ctrl <= 7'h40;
      spkr_ctrl  <= 8'h40;
    end else if (start_det) begin
      state   <= S_ADDR;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_lo  <= 1'b0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_lo  <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
        shreg   <= {shreg[6:0], sda_s};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          sda_lo <= 1'b0;
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= '0;
          in_ack  <= 1'b1;
          sda_lo  <= 1'b1;
          case (state)
            S_ADDR: begin
              if (addr_hit) state <= S_SUB;
              else begin
                state  <= S_IDLE;
                sda_lo <= 1'b0;
              end
            end
            S_SUB: begin
              subaddr <= shreg;
              state   <= S_DATA;
            end
            default: begin
              case (subaddr)
                8'h00: vol_common <= shreg[5:0];
                8'h01: vol_left   <= shreg[4:0];
                8'h02: vol_right  <= shreg[4:0];
                8'h03: bass       <= shreg[4:0];
                8'h04: treble     <= shreg[3:0];
                8'h08: scart_ctrl <= shreg[6:0];
                8'h09: spkr_ctrl  <= shreg;
                default: ;
              endcase
              subaddr <= subaddr + 8'd1;
            end
          endcase
        end
      end
    end
  end

  assign sda_drive_low = sda_lo;
  assign port1 = scart_ctrl[5];
  assign port2 = scart_ctrl[4];

endmodule

module audio_ctrl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       in_idle,
  input logic [3:0] bit_cnt,
  input logic       sda_drive_low,
  input logic [5:0] vol_common,
  input logic [6:0] scart_ctrl,
  input logic [7:0] spkr_ctrl,
  input logic       port1,
  input logic       port2
);

  // R7
  mute_at_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (scart_ctrl[6] && spkr_ctrl[6] && !port1 && !port2));

  // R10
  ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);

  // R2
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_drive_low);

  // R4
  write_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_common) |-> $past(scl_fall));

  // R3
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);

endmodule

bind audio_ctrl_i2c_slave audio_ctrl_i2c_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .in_idle(idle_w), .bit_cnt(bit_cnt), .sda_drive_low(sda_drive_low),
  .vol_common(vol_common), .scart_ctrl(scart_ctrl), .spkr_ctrl(spkr_ctrl),
  .port1(port1), .port2(port2)
);

// File: tb/audio_ctrl_i2c_slave_tb.sv
module audio_ctrl_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_drive_low;
  logic [5:0] vol_common;
  logic [4:0] vol_left, vol_right, bass;
  logic [3:0] treble;
  logic [6:0] scart_ctrl;
  logic [7:0] spkr_ctrl;
  logic port1, port2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mir [0:9];
  logic [7:0] payload [0:15];
  logic ack_bit;
  int unsigned seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_drive_low;

  audio_ctrl_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(m_scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .vol_common(vol_common), .vol_left(vol_left),
    .vol_right(vol_right), .bass(bass), .treble(treble), .scart_ctrl(scart_ctrl),
    .spkr_ctrl(spkr_ctrl), .port1(port1), .port2(port2)
  );

  function automatic logic [7:0] field_mask(input logic [7:0] s);
    case (s)
      8'h00: return 8'h3F;
      8'h01, 8'h02, 8'h03: return 8'h1F;
      8'h04: return 8'h0F;
      8'h08: return 8'h7F;
      8'h09: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare(input int got, input int exp, input string tag, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    repeat (4) @(negedge clk);
    compare(vol_common, mir[0][5:0], tag, "vol_common");
    compare(vol_left,   mir[1][4:0], tag, "vol_left");
    compare(vol_right,  mir[2][4:0], tag, "vol_right");
    compare(bass,       mir[3][4:0], tag, "bass");
    compare(treble,     mir[4][3:0], tag, "treble");
    compare(scart_ctrl, mir[8][6:0], tag, "scart_ctrl (R5)");
    compare(spkr_ctrl,  mir[9],      tag, "spkr_ctrl (R5)");
    compare(port1, mir[8][5], "R8", "port1");
    compare(port2, mir[8][4], "R8", "port2");
    compare(sda_drive_low, 0, "R10", "released");
  endtask

  task automatic wait_q;
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wait_q;
    m_scl = 1'b1; wait_q;
    m_sda = 1'b0; wait_q;
    m_scl = 1'b0; wait_q;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wait_q;
    m_scl = 1'b1; wait_q;
    m_sda = 1'b1; wait_q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q;
      m_scl = 1'b1; wait_q; wait_q;
      m_scl = 1'b0; wait_q;
    end
    m_sda = 1'b1; wait_q;
    m_scl = 1'b1; wait_q;
    ack = sda_drive_low;
    wait_q;
    m_scl = 1'b0; wait_q;
  endtask

  task automatic burst(input logic sel, input logic [6:0] a7, input logic rw,
                       input logic [7:0] sub, input int n, input string tag);
    logic hit;
    logic [7:0] s;
    addr_sel = sel;
    hit = (a7 == {6'b100000, sel}) && !rw;
    i2c_start;
    send_byte({a7, rw}, ack_bit);
    compare(ack_bit, hit, hit ? "R1" : "R2", "address ack");
    send_byte(sub, ack_bit);
    compare(ack_bit, hit, hit ? "R3" : "R2", "subaddress ack");
    s = sub;
    for (int k = 0; k < n; k++) begin
      send_byte(payload[k], ack_bit);
      compare(ack_bit, hit, hit ? "R10" : "R2", "data ack");
      if (hit) begin
        if (s < 8'd10 && field_mask(s) != 8'h00) mir[s] = payload[k] & field_mask(s);
        s = s + 8'd1;
      end
    end
    i2c_stop;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5A17);
    for (int i = 0; i < 10; i++) mir[i] = 8'h00;
    mir[8] = 8'h40;
    mir[9] = 8'h40;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R7");

    // R3 R6: full burst 00..09 with filler bytes at 05..07
    for (int k = 0; k < 10; k++) payload[k] = 8'hC0 | 8'(k * 7 + 3);
    payload[5] = 8'hFF; payload[6] = 8'hFF; payload[7] = 8'hFF;
    payload[8] = 8'h35; payload[9] = 8'hB7;
    burst(1'b0, 7'b1000000, 1'b0, 8'h00, 10, "R6");

    // R4: upper bits dropped
    for (int k = 0; k < 5; k++) payload[k] = 8'hFF;
    burst(1'b0, 7'b1000000, 1'b0, 8'h00, 5, "R4");

    // R1: high address with pin high
    payload[0] = 8'h12; payload[1] = 8'h03;
    burst(1'b1, 7'b1000001, 1'b0, 8'h01, 2, "R1");

    // R2: low address with pin high, then read bit
    payload[0] = 8'h00; payload[1] = 8'h00;
    burst(1'b1, 7'b1000000, 1'b0, 8'h08, 2, "R2");
    burst(1'b0, 7'b1000000, 1'b1, 8'h08, 2, "R2");

    // R8: unmute SCART path and raise both ports
    payload[0] = 8'h30;
    burst(1'b0, 7'b1000000, 1'b0, 8'h08, 1, "R8");
    payload[0] = 8'h20;
    burst(1'b0, 7'b1000000, 1'b0, 8'h08, 1, "R8");

    // R6: subaddresses past 09 are discarded
    payload[0] = 8'hAA; payload[1] = 8'h55; payload[2] = 8'h11;
    burst(1'b0, 7'b1000000, 1'b0, 8'h09, 3, "R6");

    // R9: repeated START in mid-transfer
    addr_sel = 1'b0;
    i2c_start;
    send_byte(8'h80, ack_bit);
    send_byte(8'h02, ack_bit);
    send_byte(8'h0B, ack_bit); mir[2] = 8'h0B;
    i2c_start;
    send_byte(8'h80, ack_bit);
    compare(ack_bit, 1, "R9", "address ack after repeated start");
    send_byte(8'h03, ack_bit);
    send_byte(8'h17, ack_bit); mir[3] = 8'h17;
    i2c_stop;
    check_all("R9");

    // R9: clock pulses after STOP without START
    send_byte(8'h80, ack_bit);
    compare(ack_bit, 0, "R9", "ack without start");
    send_byte(8'h1F, ack_bit);
    compare(ack_bit, 0, "R9", "ack without start");
    m_sda = 1'b1; wait_q;
    check_all("R9");

    // Random bursts
    for (int t = 0; t < 30; t++) begin
      logic sel;
      logic [6:0] a7;
      logic rw;
      int n;
      sel = 1'($urandom % 2);
      a7 = ($urandom % 5 == 0) ? 7'($urandom) : {6'b100000, ($urandom % 4 == 0) ? ~sel : sel};
      rw = ($urandom % 8 == 0);
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) payload[k] = 8'($urandom);
      burst(sel, a7, rw, 8'($urandom % 12), n, "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule